// File: doc/BRIEF.md
# DMA Linked-List Descriptor Loader

This block fills one DMA channel's configuration registers from a descriptor held in memory. A one-cycle start pulse gives it the descriptor's byte address. It then reads the descriptor word by word through a single-outstanding read master, and presents each field it loads as a write strobe plus a 32-bit value. The channel register file consumes these. The descriptor has ten word slots at fixed offsets. Only the first two words are mandatory. The second word holds flag bits that select which of the later slots are fetched. Slots whose flag is clear are never read, so memory past the last flagged slot does not have to exist.

Each optional slot is fetched at most once, in ascending offset order. Slot 3 carries two half-word fields, and so does slot 6. A shared slot is read once when either of its fields is wanted. The run and enable bits for control register A are written last, in the same cycle as the completion pulse, so the channel never starts on a half-written configuration. A descriptor that would straddle a 1 KB boundary is refused before any read. A read error response ends the load without the control A write.

Top module: `dma_desc_loader`

## Requirements
- R1: After reset, no read request is raised, all write strobes are low, and done_o and err_o are low.
- R2: A load begins with a read at the base address (word 0). Its data appears on reg_wdata with strobe bit 0 (next pointer) set.
- R3: Word 1 is read next, at base+4. Its strobe is bit 1 (link config). reg_wdata carries word 1 bits [9:0] in bits [9:0], with zeros above them, whatever the other bits of the word hold.
- R4: Flag bits in word 1 select the optional slots, and each selected slot is read at base+4*offset in ascending offset order. The mapping is flag → slot → strobe bit: 0→2→3 (control B), 1→3→4 (event control), 2→3→5 (CRC control), 3→4→6 (source address), 4→5→7 (destination address), 5→6→8 (source stride), 6→6→9 (destination stride), 7→7→10 (size), 8→8→11 (pattern), 9→9→12 (CRC data). Slots with no flag set are not read, and their strobes never rise.
- R5: Slot 3 and slot 6 are each read once, even when both of their half-word flags are set. Every strobe that belongs to such a slot rises in the same cycle, and reg_wdata carries the whole word. Event control and source stride are in bits [15:0]; CRC control and destination stride are in bits [31:16].
- R6: evt_capable is sampled at start. When it is low, flag 1 is ignored: strobe bit 4 never rises, and slot 3 is read only if flag 2 is set.
- R7: After every other write, strobe bit 2 (control A) rises once. reg_wdata[3:0] then equals word 1 bits [19:16] (list enable, channel enable, software force, run in standby), and the upper bits are zero. This happens in the same cycle as done_o.
- R8: The load is refused if the base address's offset within its 1 KB region, plus 40, exceeds 1024. In that case done_o and err_o pulse together, no read is issued and no strobe rises. Every read that is issued lies in the same 1 KB region as the base.
- R9: A read answered with rd_rsp_err ends the load. done_o and err_o then pulse together, no further read is issued, and no write happens for that word or for control A.
- R10: While rd_req_valid is high and rd_req_ready is low, the request stays raised and rd_addr stays unchanged.
- R11: A start pulse that arrives while a load is in progress is ignored.
- R12: done_o is a single-cycle pulse, raised once per load. err_o is high only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (pulse) |
| base_addr | input | AW | Descriptor byte address, sampled with start |
| evt_capable | input | 1 | Channel has event support, sampled with start |
| rd_req_valid | output | 1 | Read request raised |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | AW | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_data | input | 32 | Read response word |
| rd_rsp_err | input | 1 | Read response is an error |
| reg_we | output | 13 | Per-register write strobes, bit map in R2–R7 |
| reg_wdata | output | 32 | Value written with the strobes |
| done_o | output | 1 | Load finished (pulse) |
| err_o | output | 1 | Load refused or aborted, valid with done_o |

## Verification
Some properties are checked on every clock by the assertions: every issued read stays in the base's 1 KB region, a stalled request holds, the control A strobe coincides exactly with a successful done pulse, nothing is written on an error pulse, event control is never written for a channel without event support, and done lasts a single cycle. Other behaviour can only be shown by the bench's scenarios. These are the exact address order of the reads, the skipping of unflagged slots, the single read of a shared half-word slot, the masking of the link-config value, the exact boundary at offset 984 against 988, aborts at several offsets, and a start pulse ignored mid-load. The reference model predicts each of these from the descriptor contents.

// File: rtl/dma_desc_loader.sv
module dma_desc_loader #(
  parameter int AW = 32,
  parameter int REGION_LG2 = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic          evt_capable,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rsp_valid,
  input  logic [31:0]   rd_rsp_data,
  input  logic          rd_rsp_err,
  output logic [12:0]   reg_we,
  output logic [31:0]   reg_wdata,
  output logic          done_o,
  output logic          err_o
);
  localparam int NWORDS = 10;
  localparam int DESC_BYTES = 4 * NWORDS;
  localparam int OFS_W = 4;
  localparam int NFLAG = 10;
  localparam int RW = REGION_LG2 + 1;
  localparam int W_NEXT = 0, W_LLCFG = 1, W_CTRLA = 2, W_CTRLB = 3, W_EVCTRL = 4,
                 W_CRCCTRL = 5, W_SSA = 6, W_DSA = 7, W_SSTRD = 8, W_DSTRD = 9,
                 W_XSIZ = 10, W_PDAT = 11, W_CRCDAT = 12;
  localparam int F_CTRLB = 0, F_EV = 1, F_CRCC = 2, F_SSA = 3, F_DSA = 4,
                 F_SSTRD = 5, F_DSTRD = 6, F_XSIZ = 7, F_PDAT = 8, F_CRCDAT = 9;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_COMMIT, S_FIN} st_t;

  st_t              st;
  logic [AW-1:0]    base_q;
  logic [OFS_W-1:0] ofs;
  logic [NFLAG-1:0] flags_q;
  logic [3:0]       ctrl_q;
  logic             evt_q, err_q;
  logic [RW-1:0]    end_ofs;
  logic             crosses;
  logic [NFLAG-1:0] flags_eff;
  logic [NWORDS-1:0] need;
  logic [OFS_W-1:0] nxt;
  logic             have_nxt;
  logic [12:0]      we_mask;

  assign end_ofs   = {1'b0, base_addr[REGION_LG2-1:0]} + RW'(DESC_BYTES);
  assign crosses   = end_ofs > RW'(1 << REGION_LG2);
  assign flags_eff = (ofs == OFS_W'(1)) ? rd_rsp_data[NFLAG-1:0] : flags_q;

  assign rd_req_valid = (st == S_REQ);
  assign rd_addr      = base_q + AW'({ofs, 2'b00});
  assign done_o       = (st == S_FIN);
  assign err_o        = done_o & err_q;

  always_comb begin
    need    = '0;
    need[0] = 1'b1;
    need[1] = 1'b1;
    need[2] = flags_eff[F_CTRLB];
    need[3] = (flags_eff[F_EV] & evt_q) | flags_eff[F_CRCC];
    need[4] = flags_eff[F_SSA];
    need[5] = flags_eff[F_DSA];
    need[6] = flags_eff[F_SSTRD] | flags_eff[F_DSTRD];
    need[7] = flags_eff[F_XSIZ];
    need[8] = flags_eff[F_PDAT];
    need[9] = flags_eff[F_CRCDAT];
  end

  always_comb begin
    have_nxt = 1'b0;
    nxt      = '0;
    for (int w = NWORDS - 1; w >= 1; w--) begin
      if (need[w] && OFS_W'(w) > ofs) begin
        have_nxt = 1'b1;
        nxt      = OFS_W'(w);
      end
    end
  end

  always_comb begin
    we_mask = '0;
    case (ofs)
      4'd0: we_mask[W_NEXT]  = 1'b1;
      4'd1: we_mask[W_LLCFG] = 1'b1;
      4'd2: we_mask[W_CTRLB] = 1'b1;
      4'd3: begin
        we_mask[W_EVCTRL]  = flags_q[F_EV] & evt_q;
        we_mask[W_CRCCTRL] = flags_q[F_CRCC];
      end
      4'd4: we_mask[W_SSA] = 1'b1;
      4'd5: we_mask[W_DSA] = 1'b1;
      4'd6: begin
        we_mask[W_SSTRD] = flags_q[F_SSTRD];
        we_mask[W_DSTRD] = flags_q[F_DSTRD];
      end
      4'd7: we_mask[W_XSIZ]   = 1'b1;
      4'd8: we_mask[W_PDAT]   = 1'b1;
      4'd9: we_mask[W_CRCDAT] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base_q    <= '0;
      ofs       <= '0;
      flags_q   <= '0;
      ctrl_q    <= '0;
      evt_q     <= 1'b0;
      err_q     <= 1'b0;
      reg_we    <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= '0;
      case (st)
        S_IDLE: if (start) begin
          base_q  <= base_addr;
          evt_q   <= evt_capable;
          ofs     <= '0;
          flags_q <= '0;
          err_q   <= crosses;
          st      <= crosses ? S_FIN : S_REQ;
        end
        S_REQ: if (rd_req_ready) st <= S_WAIT;
        S_WAIT: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            reg_we    <= we_mask;
            reg_wdata <= (ofs == OFS_W'(1)) ? {22'b0, rd_rsp_data[NFLAG-1:0]} : rd_rsp_data;
            if (ofs == OFS_W'(1)) begin
              flags_q <= rd_rsp_data[NFLAG-1:0];
              ctrl_q  <= rd_rsp_data[19:16];
            end
            if (have_nxt) begin
              ofs <= nxt;
              st  <= S_REQ;
            end else begin
              st <= S_COMMIT;
            end
          end
        end
        S_COMMIT: begin
          reg_we[W_CTRLA] <= 1'b1;
          reg_wdata       <= {28'b0, ctrl_q};
          st              <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_same_region: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_addr[AW-1:REGION_LG2] == base_q[AW-1:REGION_LG2]);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  a_r7_commit_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> reg_we[W_CTRLA]);

  a_r7_commit_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we[W_CTRLA] |-> (done_o && !err_o));

  a_r9_silent_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (reg_we == '0));

  a_r6_event_gate: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we[W_EVCTRL] |-> evt_q);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r12_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
endmodule

// File: tb/dma_desc_loader_tb_top.sv
`timescale 1ns/1ps
module dma_desc_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        evt_capable = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        rd_rsp_err = 1'b0;
  logic [12:0] reg_we;
  logic [31:0] reg_wdata;
  logic        done_o, err_o;

  always #2 clk = ~clk;

  dma_desc_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .evt_capable(evt_capable), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0, done_cnt = 0;
  bit mon_on = 0, stall_mode = 0, exp_err = 0;
  int rsp_lat = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr [$];
  logic [12:0] exp_we [$];
  logic [31:0] exp_d [$];
  string cur_tag = "";

  // flag index -> descriptor slot, and flag index -> strobe bit
  int f_slot [10] = '{2, 3, 3, 4, 5, 6, 6, 7, 8, 9};
  int f_strb [10] = '{3, 4, 5, 6, 7, 8, 9, 10, 11, 12};

  function automatic void chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s [%s]: actual=%0h expected=%0h", req, what, cur_tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] mkcfg(logic [3:0] ctrl, logic [9:0] flags, logic [5:0] junk);
    return {12'hA5C, ctrl, junk, flags};
  endfunction

  bit prev_stall = 0;
  logic [31:0] prev_addr = '0;
  bit rsp_pend = 0;
  int rsp_cnt = 0;
  logic [31:0] rsp_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
    if (mon_on) begin
      if (prev_stall)
        chk(rd_req_valid && rd_addr == prev_addr, "R10", "stalled request held",
            {31'b0, rd_req_valid, rd_addr}, {32'h1, prev_addr});
      if (reg_we != '0) begin
        if (exp_we.size() == 0) chk(0, "R4", "unexpected write strobe", reg_we, 0);
        else begin
          logic [12:0] ew; logic [31:0] ed;
          ew = exp_we.pop_front(); ed = exp_d.pop_front();
          chk(reg_we == ew, ew[2] ? "R7" : "R4", "strobe set", reg_we, ew);
          chk(reg_wdata == ed, ew[1] ? "R3" : (ew[2] ? "R7" : "R5"), "write value", reg_wdata, ed);
        end
      end
      if (done_o) begin
        done_cnt++;
        chk(err_o == exp_err, exp_err ? "R9" : "R12", "error flag at done", err_o, exp_err);
        if (!exp_err) chk(reg_we[2], "R7", "control A commit with done", reg_we, 13'h4);
        chk(exp_we.size() == 0, "R7", "writes outstanding at done", exp_we.size(), 0);
      end else begin
        chk(!err_o, "R12", "error without done", err_o, 0);
      end
    end
    rd_rsp_valid = 1'b0;
    rd_rsp_err   = 1'b0;
    if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_err   = (rsp_addr == err_addr);
        rd_rsp_data  = mem.exists(rsp_addr) ? mem[rsp_addr] : 32'hBAD0_BAD0;
        rsp_pend     = 0;
      end else rsp_cnt--;
    end
    rd_req_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
    prev_stall   = mon_on && rd_req_valid && !rd_req_ready;
    prev_addr    = rd_addr;
    if (mon_on && rd_req_valid && rd_req_ready) begin
      if (exp_addr.size() == 0) chk(0, "R4", "unexpected read", rd_addr, 0);
      else begin
        logic [31:0] ea;
        ea = exp_addr.pop_front();
        chk(rd_addr == ea, "R4", "read address order", rd_addr, ea);
      end
      rsp_pend = 1; rsp_cnt = rsp_lat; rsp_addr = rd_addr;
    end
  end

  task automatic run_load(input string tag, input logic [31:0] base, input bit evt,
                          input logic [31:0] cfg, input int err_ofs, input bit stall,
                          input int lat, input bit poke);
    bit abort;
    int d0, t;
    logic [12:0] m;
    cur_tag = tag;
    mem.delete(); exp_addr.delete(); exp_we.delete(); exp_d.delete();
    stall_mode = stall; rsp_lat = lat;
    err_addr = (err_ofs >= 0) ? base + 32'(4 * err_ofs) : 32'hFFFF_FFFF;
    for (int w = 0; w < 10; w++)
      mem[base + 32'(4 * w)] = (w == 1) ? cfg : (32'h1357_9BDF ^ (32'(w) * 32'h0111_1011) ^ base);
    exp_err = 0; abort = 0;
    if ({1'b0, base[9:0]} + 11'd40 > 11'd1024) exp_err = 1;
    else begin
      for (int w = 0; w < 10; w++) begin
        if (abort) break;
        m = '0;
        if (w == 0) m = 13'h1;
        else if (w == 1) m = 13'h2;
        else for (int f = 0; f < 10; f++)
          if (f_slot[f] == w && cfg[f] && !(f == 1 && !evt)) m[f_strb[f]] = 1'b1;
        if (m != '0) begin
          exp_addr.push_back(base + 32'(4 * w));
          if (w == err_ofs) begin abort = 1; exp_err = 1; end
          else begin
            exp_we.push_back(m);
            exp_d.push_back(w == 1 ? {22'b0, cfg[9:0]} : mem[base + 32'(4 * w)]);
          end
        end
      end
      if (!exp_err) begin exp_we.push_back(13'h4); exp_d.push_back({28'b0, cfg[19:16]}); end
    end
    d0 = done_cnt;
    @(negedge clk); base_addr = base; evt_capable = evt; start = 1'b1;
    @(negedge clk); start = 1'b0; base_addr = 32'h0;
    if (poke) begin
      repeat (3) @(negedge clk);
      base_addr = 32'h0000_03FC; evt_capable = ~evt; start = 1'b1;  // R11 ignored while busy
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && t < 2000) begin @(negedge clk); t++; end
    chk(done_cnt == d0 + 1, "R12", "one done per load", done_cnt - d0, 1);
    chk(exp_addr.size() == 0, exp_err ? "R8" : "R4", "reads missing", exp_addr.size(), 0);
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, poke ? "R11" : "R12", "no extra done", done_cnt - d0, 1);
    chk(reg_we == '0 && !rd_req_valid, "R11", "quiet after load", {reg_we, rd_req_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req_valid && reg_we == '0 && !done_o && !err_o, "R1", "state in reset",
        {rd_req_valid, reg_we, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req_valid && reg_we == '0 && !done_o && !err_o, "R1", "state after reset",
        {rd_req_valid, reg_we, done_o, err_o}, 0);
    mon_on = 1;
    run_load("R2 R4 R5 all flags", 32'h0000_1000, 1, mkcfg(4'b0011, 10'h3FF, 6'h2A), -1, 0, 0, 0);
    run_load("R6 all flags no events", 32'h0000_2040, 0, mkcfg(4'b1010, 10'h3FF, 6'h00), -1, 1, 2, 0);
    run_load("R6 event flag only", 32'h0000_3000, 0, mkcfg(4'b0101, 10'h002, 6'h3F), -1, 0, 1, 0);
    run_load("R7 no optional", 32'h0000_4100, 1, mkcfg(4'b1111, 10'h000, 6'h15), -1, 0, 0, 0);
    run_load("R3 R4 sparse", 32'h0000_5200, 1, mkcfg(4'b0110, 10'h241, 6'h3F), -1, 1, 1, 0);
    run_load("R5 dest stride only", 32'h0000_6300, 1, mkcfg(4'b1000, 10'h040, 6'h01), -1, 0, 3, 0);
    run_load("R5 crc ctrl only", 32'h0000_6400, 1, mkcfg(4'b0001, 10'h004, 6'h01), -1, 1, 0, 0);
    run_load("R8 last legal base", 32'h0000_03D8, 1, mkcfg(4'b0011, 10'h3FF, 6'h00), -1, 0, 0, 0);
    run_load("R8 crossing base", 32'h0000_03DC, 1, mkcfg(4'b0011, 10'h3FF, 6'h00), -1, 0, 0, 0);
    run_load("R8 crossing high region", 32'h0001_07E0, 0, mkcfg(4'b0011, 10'h001, 6'h00), -1, 1, 0, 0);
    run_load("R9 error on word 5", 32'h0000_7000, 1, mkcfg(4'b0011, 10'h3FF, 6'h00), 5, 0, 1, 0);
    run_load("R9 error on word 0", 32'h0000_7800, 1, mkcfg(4'b0011, 10'h3FF, 6'h00), 0, 0, 0, 0);
    run_load("R9 error on word 1", 32'h0000_7900, 1, mkcfg(4'b1111, 10'h3FF, 6'h00), 1, 1, 0, 0);
    run_load("R10 R11 busy start", 32'h0000_8000, 1, mkcfg(4'b1100, 10'h3FF, 6'h00), -1, 1, 2, 1);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule